// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a synchronous memory. A burst starts when either of two address-status strobes is high at a clock edge. The full external address is then captured and presented as the first beat. On later edges the advance input (active low) steps the two low address bits to the next beat. When advance is high, the current beat is held.

The burst order is chosen at the start of each burst by a mode input. In linear order the low bits count upward from the start value and wrap modulo four. In interleaved order each beat is the start value XOR the beat number. The address bits above the low pair are taken at load and are never touched by stepping, so a burst never carries into them. After the fourth beat the sequence wraps back to the start value and carries on, with no flag.

The mode input is sampled only when a burst is loaded. The pad that drives it should pull it high when it is left unconnected, so that interleaved order is the default.

Top module: `burst_addr_seq`

## Requirements
- R1: One clock edge with rst_n low sets addr_o to all zeros and the stored order to interleaved.
- R2: If start_p or start_c is high at an edge, addr_o equals the addr_i value sampled at that edge from the following cycle on. Either strobe alone is enough.
- R3: A load takes priority over advance. If a strobe and adv_n low arrive together, the result is the loaded address and not a step.
- R4: With both strobes low and adv_n high, addr_o keeps its value.
- R5: Mode 0 at load selects linear order. Each step adds 1 modulo 4 to addr_o[1:0], for example 01, 10, 11, 00.
- R6: Mode 1 at load selects interleaved order. Beat k has addr_o[1:0] = start XOR k, for example start 10 gives 10, 11, 00, 01.
- R7: After three steps, a fourth step returns addr_o[1:0] to the start value, and stepping continues in the same order.
- R8: addr_o[ADDR_W-1:2] stays at the value captured at load through all steps and wraps.
- R9: A change on mode_i between loads has no effect on the order until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_p | input | 1 | First address-status strobe, active high |
| start_c | input | 1 | Second address-status strobe, active high |
| adv_n | input | 1 | Step to the next beat, active low |
| mode_i | input | 1 | Order for the next load: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External address |
| addr_o | output | ADDR_W | Address of the current beat |

## Verification
Two things can happen in the same cycle: a new burst is loaded while the advance input is low, and the mode input changes while a burst is in progress. The bench drives a strobe together with adv_n low in the middle of a burst, in both orders and from both strobes. It then expects the freshly loaded address and not a step of the old burst. It also toggles mode_i between loads, on cycles that hold and on cycles that step, and a behavioural model checks every cycle that the order chosen at the last load still applies.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst address sequencer.
// Assumes: the order code is one bit; 0 is linear and 1 is interleaved.
package burst_seq_pkg;
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/beat_ctr.sv
// Beat counter. It clears when a burst loads and counts up by one on each step.
// Assumes: clear has priority over step, and the count wraps freely.
module beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);
    // Count beats since the last load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/addr_capture.sv
// Load register. It stores the start low bits, the upper address bits and the
// order at the start of a burst.
// Assumes: all three hold their values between loads.
module addr_capture
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2,
    localparam int UP_W  = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mode_i,
    output logic [BEAT_W-1:0] start_q,
    output logic [UP_W-1:0]   upper_q,
    output order_e            order_q
);
    // Capture the address and the order on load; reset to zero and interleaved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            upper_q <= '0;
            order_q <= ORD_XOR;
        end else if (load) begin
            start_q <= addr_i[BEAT_W-1:0];
            upper_q <= addr_i[ADDR_W-1:BEAT_W];
            order_q <= mode_i ? ORD_XOR : ORD_LINEAR;
        end
    end
endmodule

// File: rtl/order_map.sv
// Order map. It combines the start value with the beat count into the low
// address bits, by addition (linear) or by XOR (interleaved).
// Assumes: purely combinational, and the result is taken modulo 2**BEAT_W.
module order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] cnt,
    input  order_e            order,
    output logic [BEAT_W-1:0] beat
);
    logic [BEAT_W-1:0] lin_beat;
    logic [BEAT_W-1:0] xor_beat;

    // Interleaved bits, one per position.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign xor_beat[b] = start[b] ^ cnt[b];
    end

    // Linear wrap-around sum.
    assign lin_beat = start + cnt;

    // Pick the order chosen at load.
    always_comb begin
        case (order)
            ORD_LINEAR: beat = lin_beat;
            default:    beat = xor_beat;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer top. It loads on either strobe and steps the low
// bits on advance, in the order chosen at load; the upper bits are held.
// Assumes: strobes active high, advance active low, synchronous active-low reset.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2,
    localparam int UP_W  = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_p,
    input  logic              start_c,
    input  logic              adv_n,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic              load;
    logic              step;
    logic [BEAT_W-1:0] start_q;
    logic [UP_W-1:0]   upper_q;
    order_e            order_q;
    logic [BEAT_W-1:0] cnt;
    logic [BEAT_W-1:0] beat;

    // Load on either strobe; step only when no load is present.
    assign load = start_p | start_c;
    assign step = ~load & ~adv_n;

    addr_capture #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .load(load), .addr_i(addr_i),
        .mode_i(mode_i), .start_q(start_q), .upper_q(upper_q), .order_q(order_q)
    );

    beat_ctr #(.CNT_W(BEAT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clear(load), .step(step), .cnt(cnt)
    );

    order_map #(.BEAT_W(BEAT_W)) u_map (
        .start(start_q), .cnt(cnt), .order(order_q), .beat(beat)
    );

    // Join the held upper bits and the current beat.
    assign addr_o = {upper_q, beat};
endmodule

// File: rtl/burst_addr_seq_chk.sv
// Assertion checker for burst_addr_seq, bound to every instance.
// Assumes: it sees the top ports and the stored start value and order.
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_p,
    input logic              start_c,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr_o,
    input logic [ADDR_W-1:0] addr_i,
    input logic [BEAT_W-1:0] start_q,
    input order_e            order_q
);
    logic ld;
    assign ld = start_p | start_c;

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0 && order_q == ORD_XOR));

    // R2 and R3: a load wins even when adv_n is low.
    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> addr_o == $past(addr_i));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv_n) |=> $stable(addr_o));

    // R5 and R7: the linear step wraps.
    p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv_n && order_q == ORD_LINEAR) |=>
        addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1));

    p_xor_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv_n && order_q == ORD_XOR) |=>
        (addr_o[BEAT_W-1:0] ^ start_q) ==
        BEAT_W'($past(addr_o[BEAT_W-1:0] ^ start_q) + 1'b1));

    p_upper_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

    p_order_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(order_q));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .start_c(start_c),
    .adv_n(adv_n), .addr_o(addr_o), .addr_i(addr_i),
    .start_q(start_q), .order_q(order_q)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int PERIOD = 10;
    localparam int AW     = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_p = 1'b0, start_c = 1'b0, adv_n = 1'b1, mode_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // Reference state: start value, beats since load, upper bits, mode.
    int m_start = 0, m_cnt = 0, m_upper = 0, m_mode = 1;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start_p(start_p), .start_c(start_c),
        .adv_n(adv_n), .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // Behavioural reference, updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_start <= 0; m_cnt <= 0; m_upper <= 0; m_mode <= 1;
        end else if (start_p || start_c) begin
            m_start <= addr_i % 4; m_upper <= addr_i / 4; m_cnt <= 0;
            m_mode <= mode_i;
        end else if (!adv_n) begin
            m_cnt <= (m_cnt + 1) % 4;
        end
    end

    function automatic int expect_addr();
        int lo;
        lo = m_mode ? (m_start ^ m_cnt) : ((m_start + m_cnt) % 4);
        return m_upper * 4 + lo;
    endfunction

    task automatic compare();
        int e;
        e = expect_addr();
        checks++;
        if (int'(addr_o) !== e) begin
            errors++;
            $display("FAIL %s addr_o=%h expected=%h", tag, addr_o, e[AW-1:0]);
        end
    endtask

    // One cycle: drive at the falling edge, compare at the next falling edge.
    task automatic cyc(input bit sp, input bit sc, input bit an, input bit md,
                       input logic [AW-1:0] a, input string t);
        start_p = sp; start_c = sc; adv_n = an; mode_i = md; addr_i = a; tag = t;
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(PERIOD*200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        compare();                                    // R1 reset value
        rst_n = 1'b1;
        // R1 interleaved default: step from reset without any load
        cyc(0, 0, 0, 0, '0, "R1");
        cyc(0, 0, 0, 0, '0, "R1");
        // R2 load through start_p, interleaved, start 10 (R6)
        cyc(1, 0, 1, 1, 17'h1A5F6, "R2");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 17'h00003, "R6");
        cyc(0, 0, 0, 1, '0, "R7");                   // wraps and continues
        // R4 hold with adv_n high
        cyc(0, 0, 1, 1, 17'h1FFFF, "R4");
        cyc(0, 0, 1, 0, 17'h00000, "R4");
        // R2 load through start_c, linear, start 01 (R5)
        cyc(0, 1, 1, 0, 17'h0ABC1, "R2");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 17'h1FFFF, "R5");
        cyc(0, 0, 0, 0, '0, "R7");
        cyc(0, 0, 0, 0, '0, "R8");
        // R9 mode toggles mid-burst, on both hold and step cycles
        cyc(0, 0, 0, 1, '0, "R9");
        cyc(0, 0, 1, 1, '0, "R9");
        cyc(0, 0, 0, 1, '0, "R9");
        // R3 load with adv_n low mid-burst, each strobe, each order
        cyc(1, 0, 0, 1, 17'h13337, "R3");
        cyc(0, 0, 0, 0, '0, "R6");
        cyc(0, 1, 0, 0, 17'h04442, "R3");
        cyc(0, 0, 0, 1, '0, "R5");
        cyc(1, 1, 0, 1, 17'h1FFFD, "R3");
        // Sweep every start value in both orders through a full wrap (R7, R8)
        for (int md = 0; md < 2; md++)
            for (int s = 0; s < 4; s++) begin
                cyc(1, 0, 1, md[0], AW'(17'h15550 + s), "R2");
                for (int k = 0; k < 5; k++) cyc(0, 0, 0, ~md[0], '1, "R7");
                cyc(0, 0, 1, md[0], '0, "R8");
            end
        // R1 reset mid-burst
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 17'h1FFFF, "R1");
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, '0, "R1");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule